// File: doc/BRIEF.md
# Burst-of-Two Dual-Port SRAM Model

This block is a synthesizable behavioural model of a quad-data-rate style static memory. It has a read data port and a write data port that are fully separate. Every access moves a pair of words. One internal clock runs at twice the external K rate, and alternate cycles stand for the rising K edge and the rising K# edge. A read request and a write request are sampled independently in the same K cycle, so both ports can work at once.

A write request carries its first data word and byte-lane enables in the K half. Its pair address, second word and second set of enables follow in the K# half. A read request carries its pair address in the K half. The two read words come back one and a half K cycles later, first word then second word. The echo outputs toggle on every internal cycle, whether or not data is being driven, so a receiver can use them as a data strobe.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst` is high, `cq` is 1, `cq_n` is 0, `q_oe` is 0 and `q` is zero. Every memory word is cleared, so a read issued right after reset returns zeros.
- R2: The cycle after reset is a K half, marked by `cq`=1. The halves then alternate. If `rd_n` is low in a K-half cycle t, the read uses pair address `addr`. Word index {addr,0} is on `q` in cycle t+3 (a K# half). Word index {addr,1} is on `q` in cycle t+4. `q_oe` is 1 in both cycles.
- R3: If `wr_n` is low in a K-half cycle t, a write starts. `wdata` in cycle t is stored at word {A,0}. `wdata` in cycle t+1 is stored at word {A,1}. A is the value of `addr` in cycle t+1.
- R4: For each beat, lane i is bits [LANE*i+LANE-1 : LANE*i], with LANE = DW/NB. The lane is written when `bwe_n[i]` is 0 in that beat's cycle, and keeps its old contents when the bit is 1.
- R5: A read and a write may start in the same K cycle. If both use the same pair, the read returns the newly written data, merged through the byte enables. If they use different pairs, each proceeds unaffected.
- R6: `q_oe` is 0 and `q` is zero in every cycle that carries no read beat. Reads issued in consecutive K cycles produce an unbroken stream of beats.
- R7: `rd_n` and `wr_n` are sampled only in K-half cycles, and a low level in a K# half is ignored. `addr`, `wdata` and `bwe_n` have no effect when neither port is selected.
- R8: After reset, `cq` and `cq_n` are always complementary and both toggle every cycle, including cycles where `q_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read request, sampled in K halves |
| wr_n | input | 1 | Active-low write request, sampled in K halves |
| addr | input | AW | Read pair address (K half) or write pair address (K# half) |
| wdata | input | DW | Write data word for the current half |
| bwe_n | input | NB | Active-low byte-lane write enables for the current half |
| q | output | DW | Read data beat, zero when idle |
| q_oe | output | 1 | High while `q` carries a read beat |
| cq | output | 1 | Echo clock, high in K halves |
| cq_n | output | 1 | Complementary echo clock, high in K# halves |

## Verification
A read and a write can start in the same K cycle. The case that matters is when both name the same pair. The read's first word is fetched one internal cycle after the write commits, so it must see the new bytes. The bench drives every pair with both requests at once and with mixed byte enables. It also drives a second sweep in which the two requests name different pairs. Each returned beat is judged against a reference array that the bench updates in request order, with the write applied before the read of the same K cycle.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

    // Half of the K period that the current internal cycle stands for
    typedef enum logic {
        HALF_KN = 1'b0,
        HALF_K  = 1'b1
    } half_e;

    localparam int DEF_AW = 4;
    localparam int DEF_DW = 36;
    localparam int DEF_NB = 4;

    localparam int RD_LAT = 3;

endpackage

// File: rtl/qdr_b2_phase.sv
module qdr_b2_phase
    import qdr_b2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output half_e half,
    output logic  cq,
    output logic  cq_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            half <= HALF_K;
            cq   <= 1'b1;
            cq_n <= 1'b0;
        end else begin
            half <= (half == HALF_K) ? HALF_KN : HALF_K;
            cq   <= ~cq;
            cq_n <= ~cq_n;
        end
    end

    // R8
    echo_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cq != $past(cq)));

    // R8
    echo_compl_chk: assert property (@(posedge clk) disable iff (rst)
        cq != cq_n);

endmodule

// File: rtl/qdr_b2_wr_cap.sv
module qdr_b2_wr_cap
    import qdr_b2_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    parameter int NB = DEF_NB
) (
    input  logic          clk,
    input  logic          rst,
    input  half_e         half,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] bwe_n,
    output logic          we,
    output logic [AW-1:0] wbase,
    output logic [DW-1:0] wd0,
    output logic [DW-1:0] wd1,
    output logic [NB-1:0] wb0,
    output logic [NB-1:0] wb1
);

    logic          pend;
    logic [DW-1:0] d0_q;
    logic [NB-1:0] b0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            d0_q <= '0;
            b0_q <= '1;
        end else if (half == HALF_K) begin
            pend <= ~wr_n;
            if (!wr_n) begin
                d0_q <= wdata;
                b0_q <= bwe_n;
            end
        end else begin
            pend <= 1'b0;
        end
    end

    assign we    = pend && (half == HALF_KN);
    assign wbase = addr;
    assign wd0   = d0_q;
    assign wd1   = wdata;
    assign wb0   = b0_q;
    assign wb1   = bwe_n;

    // R7
    wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(!wr_n && (half == HALF_K)));

endmodule

// File: rtl/qdr_b2_array.sv
module qdr_b2_array
    import qdr_b2_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    parameter int NB = DEF_NB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wbase,
    input  logic [DW-1:0] wd0,
    input  logic [DW-1:0] wd1,
    input  logic [NB-1:0] wb0,
    input  logic [NB-1:0] wb1,
    input  logic [AW:0]   raddr,
    output logic [DW-1:0] rdata
);

    localparam int WORDS = 2 ** (AW + 1);
    localparam int LANE  = DW / NB;

    logic [DW-1:0] mem [WORDS];
    logic [AW:0]   ix0, ix1;
    logic [DW-1:0] m0, m1;

    assign ix0 = {wbase, 1'b0};
    assign ix1 = {wbase, 1'b1};

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign m0[g*LANE +: LANE] = wb0[g] ? mem[ix0][g*LANE +: LANE] : wd0[g*LANE +: LANE];
        assign m1[g*LANE +: LANE] = wb1[g] ? mem[ix1][g*LANE +: LANE] : wd1[g*LANE +: LANE];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[ix0] <= m0;
            mem[ix1] <= m1;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/qdr_b2_rd_pipe.sv
module qdr_b2_rd_pipe
    import qdr_b2_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  half_e         half,
    input  logic          rd_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    output logic [AW:0]   raddr,
    output logic [DW-1:0] q,
    output logic          q_oe
);

    logic          r1, r2, r3;
    logic [AW-1:0] ra, rb;
    logic          take;

    assign take = (half == HALF_K) && !rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            r1   <= 1'b0;
            r2   <= 1'b0;
            r3   <= 1'b0;
            ra   <= '0;
            rb   <= '0;
            q    <= '0;
            q_oe <= 1'b0;
        end else begin
            r1 <= take;
            r2 <= r1;
            r3 <= r2;
            if (take) ra <= addr;
            if (r2)   rb <= ra;
            if (r2 || r3) begin
                q    <= rdata;
                q_oe <= 1'b1;
            end else begin
                q    <= '0;
                q_oe <= 1'b0;
            end
        end
    end

    assign raddr = r2 ? {ra, 1'b0} : {rb, 1'b1};

    // R2
    read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (q_oe && (half == HALF_KN)) |-> $past(!rd_n && (half == HALF_K), RD_LAT));

    // R6
    burst_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (q_oe && (half == HALF_KN)) |=> q_oe);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_oe |-> (q == '0));

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
    import qdr_b2_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    parameter int NB = DEF_NB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] bwe_n,
    output logic [DW-1:0] q,
    output logic          q_oe,
    output logic          cq,
    output logic          cq_n
);

    half_e         half;
    logic          we;
    logic [AW-1:0] wbase;
    logic [DW-1:0] wd0, wd1, rdata;
    logic [NB-1:0] wb0, wb1;
    logic [AW:0]   raddr;

    qdr_b2_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .half (half),
        .cq   (cq),
        .cq_n (cq_n)
    );

    qdr_b2_wr_cap #(.AW(AW), .DW(DW), .NB(NB)) u_wr (
        .clk   (clk),
        .rst   (rst),
        .half  (half),
        .wr_n  (wr_n),
        .addr  (addr),
        .wdata (wdata),
        .bwe_n (bwe_n),
        .we    (we),
        .wbase (wbase),
        .wd0   (wd0),
        .wd1   (wd1),
        .wb0   (wb0),
        .wb1   (wb1)
    );

    qdr_b2_array #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wbase (wbase),
        .wd0   (wd0),
        .wd1   (wd1),
        .wb0   (wb0),
        .wb1   (wb1),
        .raddr (raddr),
        .rdata (rdata)
    );

    qdr_b2_rd_pipe #(.AW(AW), .DW(DW)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .half  (half),
        .rd_n  (rd_n),
        .addr  (addr),
        .rdata (rdata),
        .raddr (raddr),
        .q     (q),
        .q_oe  (q_oe)
    );

endmodule

// File: tb/sim_qdr_b2_sram.sv
module sim_qdr_b2_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NB = 2;
    localparam int PAIRS = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] bwe_n = '1;
    logic [DW-1:0] q;
    logic          q_oe, cq, cq_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic prev_cq = 1'b0;

    logic [DW-1:0] ref_mem [2*PAIRS];
    logic [DW-1:0] eq_d [$];
    int            eq_c [$];
    string         eq_t [$];

    qdr_b2_sram #(.AW(AW), .DW(DW), .NB(NB)) u0 (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .bwe_n(bwe_n), .q(q), .q_oe(q_oe), .cq(cq), .cq_n(cq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [NB-1:0] b);
        logic [DW-1:0] r;
        r[7:0]  = b[0] ? o[7:0]  : n[7:0];
        r[15:8] = b[1] ? o[15:8] : n[15:8];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int p, input int b, input int s);
        return DW'((p * 16'h0911) ^ (b * 16'h6040) ^ (s * 16'h1357) ^ 16'hA5C3);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Output monitor: data beats, idle level and echo clocks
    always @(negedge clk) begin
        if (rst) begin
            prev_cq = 1'b0;
        end else begin
            chk((cq != cq_n) && (cq != prev_cq), "R8 echo toggle", {14'd0, cq, cq_n}, {14'd0, ~prev_cq, prev_cq});
            prev_cq = cq;
            if (eq_c.size() > 0 && eq_c[0] == cyc) begin
                chk(q_oe && (q === eq_d[0]), eq_t[0], q_oe ? q : 16'hxxxx, eq_d[0]);
                void'(eq_d.pop_front());
                void'(eq_c.pop_front());
                void'(eq_t.pop_front());
            end else begin
                chk(!q_oe && (q == '0), "R6 idle output", q_oe ? q : 16'h0, 16'h0);
            end
        end
    end

    // One K period starting at the negedge of a K-half cycle
    task automatic kcyc(input bit rd, input int ra, input bit wr, input int wa,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [NB-1:0] b0, input logic [NB-1:0] b1, input string t);
        rd_n  = !rd;
        wr_n  = !wr;
        addr  = AW'(ra);
        wdata = d0;
        bwe_n = b0;
        if (wr) begin
            ref_mem[2*wa]   = mrg(ref_mem[2*wa],   d0, b0);
            ref_mem[2*wa+1] = mrg(ref_mem[2*wa+1], d1, b1);
        end
        if (rd) begin
            eq_d.push_back(ref_mem[2*ra]);   eq_c.push_back(cyc + 3); eq_t.push_back(t);
            eq_d.push_back(ref_mem[2*ra+1]); eq_c.push_back(cyc + 4); eq_t.push_back(t);
        end
        @(negedge clk);
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        addr  = AW'(wa);
        wdata = d1;
        bwe_n = b1;
        @(negedge clk);
    endtask

    task automatic read_all(input string t);
        for (int p = 0; p < PAIRS; p++) kcyc(1, p, 0, 0, 16'h0, 16'h0, 2'b11, 2'b11, t);
    endtask

    initial begin
        for (int i = 0; i < 2*PAIRS; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(cq == 1'b1 && cq_n == 1'b0, "R1 echo reset", {14'd0, cq, cq_n}, 16'h0002);
        chk(q_oe == 1'b0 && q == '0, "R1 output reset", q, 16'h0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1: cleared contents, back-to-back reads (R6)
        read_all("R1 cleared read");

        // R3: full writes to every pair, then R2 reads back to back
        for (int p = 0; p < PAIRS; p++)
            kcyc(0, 7 - p, 1, p, pat(p, 0, 1), pat(p, 1, 1), 2'b00, 2'b00, "R3 write");
        read_all("R2 read after R3 write");

        // R4: every byte-enable combination of both beats
        for (int c = 0; c < 16; c++) begin
            kcyc(0, 0, 1, c % PAIRS, ~pat(c, 0, 2), ~pat(c, 1, 2),
                 NB'(c & 3), NB'((c >> 2) & 3), "R4 lane write");
            kcyc(1, c % PAIRS, 0, 0, 16'h0, 16'h0, 2'b11, 2'b11, "R4 lane read");
        end

        // R5: read and write in the same K cycle, same pair then other pair
        for (int p = 0; p < PAIRS; p++)
            kcyc(1, p, 1, p, pat(p, 0, 3), pat(p, 1, 3), NB'(p & 3), NB'((p + 1) & 3),
                 "R5 same pair");
        for (int p = 0; p < PAIRS; p++)
            kcyc(1, (p + 3) % PAIRS, 1, p, pat(p, 0, 4), pat(p, 1, 4), 2'b00, 2'b10,
                 "R5 other pair");
        kcyc(0, 0, 0, 0, 16'h0, 16'h0, 2'b11, 2'b11, "R5 gap");
        read_all("R5 readback");

        // R7: requests only in K# halves, and deselected bus activity
        for (int p = 0; p < PAIRS; p++) begin
            rd_n = 1'b1; wr_n = 1'b1; addr = AW'(p); wdata = 16'hDEAD; bwe_n = 2'b00;
            @(negedge clk);
            rd_n = 1'b0; wr_n = 1'b0; addr = AW'(p); wdata = 16'hBEEF; bwe_n = 2'b00;
            @(negedge clk);
            rd_n = 1'b1; wr_n = 1'b1;
        end
        for (int k = 0; k < 10; k++)
            kcyc(0, k % PAIRS, 0, (k * 3) % PAIRS, 16'hFFFF, 16'h1234, 2'b00, 2'b00, "R7 idle");
        read_all("R7 readback");

        repeat (8) @(negedge clk);
        chk(eq_c.size() == 0, "R2 missing beats", 16'(eq_c.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule